// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is a two-wire serial bus target for a small configuration function. It holds two 6-bit setting registers. It can also return the level of five external input pins, and it stores one command byte that a neighbouring output selector decodes to pick where its outputs come from. The clock and data lines are sampled by the system clock through a synchroniser. The target answers by asserting a pull-down enable for the data line, which the pad turns into an open-drain driver.

A write transaction carries the target address, then a command byte, then up to two data bytes. Data bytes are held in staging and reach the registers only when the STOP condition arrives, and only while write-protect is low. After each committed write, a busy window starts. During that window the target refuses its own address, the way a non-volatile store would while it programs. A read returns either the register that the internal pointer selects or the external pin levels, depending on the stored command.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 1001_1 followed by the address pins {A1,A0}, and refuses any other address. The last address bit selects read (1) or write (0).
- R2: As the first byte after a write address, the codes 0x00, 0x01 and 1111_1xxx are acknowledged and stored on the command output. Any other code is refused and leaves the stored command unchanged.
- R3: After command 0x00 (or 0x01), the first data byte is staged for register 0 (or 1), and a second byte is staged for the other register. The registers do not change before STOP.
- R4: Bits 7:6 of a written data byte are discarded. Only bits 5:0 are stored.
- R5: A third data byte in one write is refused, and all staged bytes of that write are dropped.
- R6: While write-protect is 1, the address and the command are still acknowledged, but data bytes are refused and no register changes.
- R7: After a command of the form 1111_1xxx, any data byte is refused.
- R8: A read after a register command returns {2'b00, register}. A read after any other stored command returns {3'b000, pins[4:0]}.
- R9: Each register byte that is read or written moves the pointer to the other register.
- R10: For BUSY_CYCLES system clocks after a STOP that wrote a register, the target refuses its own address. After that it acknowledges again.
- R11: A repeated START restarts address reception.
- R12: A master NACK during a read ends the transfer. SDA is then left released until the next START.
- R13: After reset, both registers are 0, the stored command is CMD_RESET (default 0xFF), and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_pins_i | input | 2 | Low address bits {A1,A0} |
| wp_i | input | 1 | Write-protect, 1 blocks register writes |
| ext_pins_i | input | PIN_W | External pin levels readable over the bus |
| sda_pull_o | output | 1 | Pull-down enable for the data line |
| reg0_o | output | REG_W | Configuration register 0 |
| reg1_o | output | REG_W | Configuration register 1 |
| cmd_o | output | 8 | Stored command for the output selector |

## Verification
The hardest state to reach from the ports is the one after a write has been refused part-way: two bytes are already staged and the third is refused. The check is then that the STOP which follows writes nothing. The stimulus first fills both staging slots with known values and pushes a third byte. Only after STOP does it read both registers back over the bus. A second sequence addresses the target immediately after a committed STOP, so that the address lands inside the busy window.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK
   } cfgt_state_e;

   typedef enum logic [1:0] {
      K_ADDR,
      K_CMD,
      K_DATA
   } cfgt_kind_e;

   localparam logic [4:0] ADDR_FIXED = 5'b10011;

   function automatic logic is_reg_cmd(input logic [7:0] c);
      return c[7:1] == 7'b0;
   endfunction

   function automatic logic is_cmd_legal(input logic [7:0] c);
      return is_reg_cmd(c) || (c[7:3] == 5'b11111);
   endfunction
endpackage

// File: rtl/cfgt_line_sync.sv
module cfgt_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("cfgt_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic scl_p, sda_p, scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_p  <= scl_q;
         sda_p  <= sda_q;
      end
   end

   assign scl_q      = scl_sh[SYNC_STAGES-1];
   assign sda_q      = sda_sh[SYNC_STAGES-1];
   assign sda_o      = sda_q;
   assign scl_rise_o = scl_q & ~scl_p;
   assign scl_fall_o = ~scl_q & scl_p;
   assign start_o    = scl_q & scl_p & sda_p & ~sda_q;
   assign stop_o     = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/cfgt_busy_timer.sv
module cfgt_busy_timer #(
   parameter int CYCLES = 900000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("cfgt_busy_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (arm_i)      cnt <= CW'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - CW'(1);
   end

   assign busy_o = (cnt != '0);

   AST_BUSY_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> busy_o); // R10
endmodule

// File: rtl/cfgt_stage_regs.sv
module cfgt_stage_regs #(
   parameter int REG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic             sel_i,
   input  logic [REG_W-1:0] d_i,
   input  logic             cancel_i,
   input  logic             commit_i,
   input  logic             wp_i,
   output logic [REG_W-1:0] reg0_o,
   output logic [REG_W-1:0] reg1_o,
   output logic             written_o
);
   for (genvar g = 0; g < 2; g++) begin : g_slot
      logic             pend;
      logic [REG_W-1:0] hold;
      logic [REG_W-1:0] val;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend <= 1'b0;
            hold <= '0;
            val  <= '0;
         end else begin
            if (commit_i && pend && !wp_i) val <= hold;
            if (commit_i || cancel_i) begin
               pend <= 1'b0;
            end else if (we_i && (sel_i == 1'(g))) begin
               pend <= 1'b1;
               hold <= d_i;
            end
         end
      end
   end

   assign reg0_o    = g_slot[0].val;
   assign reg1_o    = g_slot[1].val;
   assign written_o = commit_i & ~wp_i & (g_slot[0].pend | g_slot[1].pend);

   AST_REG0_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg0_o != $past(reg0_o)) |-> $past(commit_i)); // R3
   AST_REG1_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg1_o != $past(reg1_o)) |-> $past(commit_i)); // R3
   AST_WP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && wp_i) |=> ($stable(reg0_o) && $stable(reg1_o))); // R6
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
   parameter int         REG_W       = 6,
   parameter int         PIN_W       = 5,
   parameter int         SYNC_STAGES = 2,
   parameter int         BUSY_CYCLES = 900000,
   parameter logic [7:0] CMD_RESET   = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic [1:0]       addr_pins_i,
   input  logic             wp_i,
   input  logic [PIN_W-1:0] ext_pins_i,
   output logic             sda_pull_o,
   output logic [REG_W-1:0] reg0_o,
   output logic [REG_W-1:0] reg1_o,
   output logic [7:0]       cmd_o
);
   import cfgt_pkg::*;

   if (REG_W < 1 || REG_W > 8 || PIN_W < 1 || PIN_W > 8) begin : g_bad_width
      $error("cfg_i2c_target: REG_W and PIN_W must lie in 1..8");
   end

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic busy, written;

   cfgt_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det));

   cfgt_state_e state;
   cfgt_kind_e  kind;
   logic [3:0]  bcnt;
   logic [7:0]  sr, tsr, cmd_q, tx_byte;
   logic [1:0]  dcnt;
   logic        rw, acked, ptr, mack, pull_q, ack_now, decide;
   logic        stage_we, cancel;

   assign decide = (state == ST_RX) && scl_fall && (bcnt == 4'd8);

   always_comb begin
      unique case (kind)
         K_ADDR:  ack_now = (sr[7:1] == {ADDR_FIXED, addr_pins_i}) && !busy;
         K_CMD:   ack_now = is_cmd_legal(sr);
         default: ack_now = is_reg_cmd(cmd_q) && !wp_i && (dcnt < 2'd2);
      endcase
   end

   assign stage_we = decide && (kind == K_DATA) && ack_now;
   assign cancel   = decide && (kind == K_DATA) && is_reg_cmd(cmd_q) && !wp_i && (dcnt >= 2'd2);

   always_comb begin
      tx_byte = '0;
      if (is_reg_cmd(cmd_q)) tx_byte[REG_W-1:0] = ptr ? reg1_o : reg0_o;
      else                   tx_byte[PIN_W-1:0] = ext_pins_i;
   end

   cfgt_stage_regs #(.REG_W(REG_W)) i_stage (
      .clk(clk), .rst_n(rst_n), .we_i(stage_we), .sel_i(ptr),
      .d_i(sr[REG_W-1:0]), .cancel_i(cancel), .commit_i(stop_det),
      .wp_i(wp_i), .reg0_o(reg0_o), .reg1_o(reg1_o), .written_o(written));

   cfgt_busy_timer #(.CYCLES(BUSY_CYCLES)) i_busy (
      .clk(clk), .rst_n(rst_n), .arm_i(written), .busy_o(busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         kind   <= K_ADDR;
         bcnt   <= '0;
         sr     <= '0;
         tsr    <= '0;
         dcnt   <= '0;
         rw     <= 1'b0;
         acked  <= 1'b0;
         ptr    <= 1'b0;
         mack   <= 1'b0;
         pull_q <= 1'b0;
         cmd_q  <= CMD_RESET;
      end else if (start_det) begin
         state  <= ST_RX;
         kind   <= K_ADDR;
         bcnt   <= '0;
         pull_q <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         pull_q <= 1'b0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise && bcnt < 4'd8) begin
                  sr   <= {sr[6:0], sda_s};
                  bcnt <= bcnt + 4'd1;
               end
               if (decide) begin
                  acked  <= ack_now;
                  pull_q <= ack_now;
                  state  <= ST_RACK;
                  if (kind == K_ADDR) rw <= sr[0];
                  if (kind == K_CMD && ack_now) begin
                     cmd_q <= sr;
                     ptr   <= sr[0];
                     dcnt  <= '0;
                  end
                  if (stage_we) begin
                     ptr  <= ~ptr;
                     dcnt <= dcnt + 2'd1;
                  end
               end
            end
            ST_RACK: if (scl_fall) begin
               pull_q <= 1'b0;
               bcnt   <= '0;
               if (!acked) begin
                  state <= ST_IDLE;
               end else if (kind == K_ADDR && rw) begin
                  tsr    <= {tx_byte[6:0], 1'b0};
                  pull_q <= ~tx_byte[7];
                  bcnt   <= 4'd1;
                  state  <= ST_TX;
               end else begin
                  state <= ST_RX;
                  kind  <= (kind == K_ADDR) ? K_CMD : K_DATA;
               end
            end
            ST_TX: if (scl_fall) begin
               if (bcnt == 4'd8) begin
                  pull_q <= 1'b0;
                  state  <= ST_TACK;
                  if (is_reg_cmd(cmd_q)) ptr <= ~ptr;
               end else begin
                  pull_q <= ~tsr[7];
                  tsr    <= {tsr[6:0], 1'b0};
                  bcnt   <= bcnt + 4'd1;
               end
            end
            ST_TACK: begin
               if (scl_rise) mack <= ~sda_s;
               if (scl_fall) begin
                  if (mack) begin
                     tsr    <= {tx_byte[6:0], 1'b0};
                     pull_q <= ~tx_byte[7];
                     bcnt   <= 4'd1;
                     state  <= ST_TX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_pull_o = pull_q;
   assign cmd_o      = cmd_q;

   AST_PULL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_o |-> (state == ST_RACK || state == ST_TX)); // R12
   AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != $past(cmd_o)) |-> is_cmd_legal(cmd_o)); // R2
   AST_BUSY_NO_ADDR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK && kind == K_ADDR && busy) |-> !sda_pull_o); // R10
endmodule

// File: tb/test_cfg_i2c_target.sv
`timescale 1ns/1ps
module test_cfg_i2c_target;
   localparam int H    = 20;
   localparam int BUSY = 3000;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
   logic [4:0] ext = 5'b10110;
   logic       sda_pull;
   logic [5:0] r0, r1;
   logic [7:0] cmd;
   wire        sda_line = sda_m & ~sda_pull;

   int n_chk = 0, n_bad = 0;

   cfg_i2c_target #(.BUSY_CYCLES(BUSY)) i_cfg_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .addr_pins_i(2'b10), .wp_i(wp), .ext_pins_i(ext),
      .sda_pull_o(sda_pull), .reg0_o(r0), .reg1_o(r1), .cmd_o(cmd));

   localparam logic [7:0] AW = 8'h9C, AR = 8'h9D, AX = 8'h9A;

   task automatic wt(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic b_start;
      sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(2);
   endtask

   task automatic b_stop;
      sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
   endtask

   task automatic b_wr(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2);
      end
      sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
      ack = ~sda_line;
      wt(H/2); scl_m = 1'b0; wt(2);
   endtask

   task automatic b_rd(input logic give_ack, output logic [7:0] d);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wt(H); scl_m = 1'b1; wt(H/2); d[i] = sda_line; wt(H/2); scl_m = 1'b0;
      end
      wt(2); sda_m = ~give_ack; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2); sda_m = 1'b1;
   endtask

   task automatic t_reset;
      chk("R13 sda released", sda_pull, 1'b0);
      chk("R13 reg0", r0, 6'h00);
      chk("R13 reg1", r1, 6'h00);
      chk("R13 command", cmd, 8'hFF);
   endtask

   task automatic t_address;
      logic a;
      b_start; b_wr(AX, a); b_stop;
      chk("R1 foreign address refused", a, 1'b0);
      b_start; b_wr(AW, a); b_stop;
      chk("R1 own address acknowledged", a, 1'b1);
   endtask

   task automatic t_command;
      logic a;
      b_start; b_wr(AW, a); b_wr(8'h05, a); b_stop;
      chk("R2 illegal code refused", a, 1'b0);
      chk("R2 command kept", cmd, 8'hFF);
      b_start; b_wr(AW, a); b_wr(8'hFA, a);
      chk("R2 selector code acknowledged", a, 1'b1);
      b_wr(8'h12, a); b_stop;
      chk("R7 data after selector code refused", a, 1'b0);
      chk("R2 selector code stored", cmd, 8'hFA);
   endtask

   task automatic t_write_pair;
      logic a0, a1, a2;
      b_start; b_wr(AW, a0); b_wr(8'h01, a0); b_wr(8'hC5, a1); b_wr(8'h2A, a2);
      chk("R3 both data bytes acknowledged", {a0, a1, a2}, 3'b111);
      chk("R3 reg0 unchanged before STOP", r0, 6'h00);
      chk("R3 reg1 unchanged before STOP", r1, 6'h00);
      b_stop; wt(4);
      chk("R4 upper bits dropped in reg1", r1, 6'h05);
      chk("R3 second byte to other register", r0, 6'h2A);
   endtask

   task automatic t_busy;
      logic a;
      b_start; b_wr(AW, a); b_stop;
      chk("R10 address refused while busy", a, 1'b0);
      wt(BUSY);
      b_start; b_wr(AW, a); b_stop;
      chk("R10 address acknowledged after window", a, 1'b1);
   endtask

   task automatic t_read_regs;
      logic a, ar;
      logic [7:0] d0, d1;
      b_start; b_wr(AW, a); b_wr(8'h00, a);
      b_start; b_wr(AR, ar);
      chk("R11 read address after repeated START", ar, 1'b1);
      b_rd(1'b1, d0); b_rd(1'b0, d1);
      chk("R8 register read format", d0, 8'h2A);
      chk("R9 pointer moved to reg1", d1, 8'h05);
      for (int k = 0; k < 2; k++) begin
         wt(H); scl_m = 1'b1; wt(H/2);
         chk("R12 SDA released after master NACK", sda_pull, 1'b0);
         wt(H/2); scl_m = 1'b0; wt(2);
      end
      b_stop;
   endtask

   task automatic t_read_pins;
      logic a;
      logic [7:0] d;
      b_start; b_wr(AW, a); b_wr(8'hFF, a);
      b_start; b_wr(AR, a); b_rd(1'b0, d); b_stop;
      chk("R8 pin read format", d, 8'h16);
   endtask

   task automatic t_third_byte;
      logic a1, a2, a3;
      logic [7:0] d0, d1;
      b_start; b_wr(AW, a1); b_wr(8'h00, a1);
      b_wr(8'h11, a1); b_wr(8'h22, a2); b_wr(8'h33, a3); b_stop;
      chk("R5 third byte refused", {a1, a2, a3}, 3'b110);
      b_start; b_wr(AW, a1); b_wr(8'h00, a1);
      b_start; b_wr(AR, a1); b_rd(1'b1, d0); b_rd(1'b0, d1); b_stop;
      chk("R5 reg0 not written after cancel", d0, 8'h2A);
      chk("R5 reg1 not written after cancel", d1, 8'h05);
   endtask

   task automatic t_protect;
      logic a0, a1, a2;
      wp = 1'b1;
      b_start; b_wr(AW, a0); b_wr(8'h01, a1); b_wr(8'h3F, a2); b_stop;
      wp = 1'b0; wt(4);
      chk("R6 address and command acknowledged", {a0, a1}, 2'b11);
      chk("R6 data refused", a2, 1'b0);
      chk("R6 reg1 unchanged", r1, 6'h05);
      chk("R6 reg0 unchanged", r0, 6'h2A);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      wt(5);
      rst_n = 1'b1;
      wt(5);
      t_reset;
      t_address;
      t_command;
      t_write_pair;
      t_busy;
      t_read_regs;
      t_read_pins;
      t_third_byte;
      t_protect;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule